// File: doc/BRIEF.md
# Integration Period Timing Controller

This block sequences the integration periods of an integrating light-to-digital converter. It runs on a base oscillator clock. From the range setting it derives a counting tick: full rate for the high ranges and every other cycle for the low ranges. A single 16-bit cycle counter serves as the integration timer.

The block has two timing modes. In internal timing mode, a width code picks a fixed number of ticks per integration. When the count completes, the block samples the converter's count and the next period begins at once. In external timing mode, integration is framed by sync strobes that arrive from the bus interface. Three strobes span one measurement, spread over two photodiode arrays. The third strobe publishes both the converter count and the number of ticks that elapsed, then starts the next measurement.

The sequencer has five states:
- `ST_IDLE`: held in reset.
- `ST_INT`: internal integration.
- `ST_XWAIT`: external mode, waiting for the first strobe.
- `ST_XA1`: external mode, integrating the first array.
- `ST_XA2`: external mode, integrating the second array.

The transitions are:
- `ST_IDLE` to `ST_INT` or `ST_XWAIT` once the block is enabled and in light-count mode. The timing-mode bit picks which.
- `ST_XWAIT` to `ST_XA1` on a strobe.
- `ST_XA1` to `ST_XA2` on a strobe.
- `ST_XA2` back to `ST_XA1` on a strobe, which also publishes the measurement.
- Any state to `ST_IDLE` when the block is disabled or the source code selects the disabled setting.
- Any active state to `ST_IDLE` when the timing configuration changes (abort).
- Any state holds itself while frozen.

Top module: `integ_timer_ctrl`

## Requirements
- R1: After reset, `integrating`, `array_sel` and `timer_ovf` are 0, and `result` and `timer_val` are all zeros.
- R2: With `ext_mode`=0, `src_sel`=2'b10 and `run_en`=1, the sequencer leaves `ST_IDLE` on the first clock edge. `result` then takes `conv_count` on the T-th tick after that edge, and again every T ticks. T is 16, 256, 4096 or 65536 for `width_sel` 2'b11, 2'b10, 2'b01 or 2'b00. In internal mode `array_sel` stays 0.
- R3: With `range_sel[1]`=1 a tick occurs on every clock cycle. With `range_sel` 2'b00 or 2'b01, a tick occurs on every second cycle, starting with the second cycle after a (re)start. Every period in clock cycles therefore doubles.
- R4: When `run_en`=0, or `src_sel` is 2'b00 or 2'b01, the next edge puts the block in `ST_IDLE`. `integrating` drops and the counter and phase clear. `result` and `timer_val` keep their values. A later start runs a full period.
- R5: While `pwr_dn`=1 or `src_sel`=2'b11, state, counter, tick phase and latched values all hold and `integrating` is 0. Timing resumes exactly where it stopped.
- R6: In external mode (`ext_mode`=1), `integrating` stays 0 until the first `sync_pulse`. After it `array_sel`=0 (first array). The second strobe sets `array_sel`=1 (second array) without publishing. Strobes are ignored while disabled.
- R7: The third strobe loads `result` from `conv_count` and loads `timer_val` with the ticks counted since the first strobe, up to but excluding the third strobe's edge. The counter restarts at 0 and `array_sel` returns to 0.
- R8: The external timer saturates at 65535. `timer_ovf` becomes 1 on the edge where the timer reaches 65535 and stays 1 until the next non-frozen `sync_pulse` clears it.
- R9: A change of `ext_mode`, `width_sel` or `range_sel` outside `ST_IDLE` aborts the period without publishing. The block passes through `ST_IDLE` for one edge and restarts from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Converter core enable; 0 holds the sequencer in reset |
| pwr_dn | input | 1 | Power-down; 1 freezes all activity |
| ext_mode | input | 1 | 0 internal timing, 1 external (strobe) timing |
| src_sel | input | 2 | 2'b10 light count, 2'b00/2'b01 disabled, 2'b11 no operation (freeze) |
| width_sel | input | 2 | Internal period length code |
| range_sel | input | 2 | Range code; bit 1 selects the full-rate tick |
| sync_pulse | input | 1 | One-cycle sync strobe from the bus interface |
| conv_count | input | 16 | Running count from the converter |
| array_sel | output | 1 | 0 first photodiode array, 1 second |
| integrating | output | 1 | Integrate enable to the converter |
| result | output | 16 | Latched converter count of the last measurement |
| timer_val | output | 16 | Latched tick count of the last external measurement |
| timer_ovf | output | 1 | Sticky external timer saturation flag |

## Verification
The assertions watch, on every cycle, properties that hold regardless of the scenario:
- the low-range tick never fires on two cycles in a row;
- the saturated counter leaves 65535 only by clearing;
- the second array is entered only on a strobe;
- disabling always drops the integrate enable;
- a freeze never disturbs the latched values;
- the overflow flag falls only on a strobe.

Only the bench scenarios can show the exact period lengths for each width and range code, the published tick counts for given strobe spacings, the resumption point after a freeze, and that an aborted period publishes nothing.

// File: rtl/integ_pkg.sv
`timescale 1ns/1ps
package integ_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_INT   = 3'd1,
        ST_XWAIT = 3'd2,
        ST_XA1   = 3'd3,
        ST_XA2   = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic       ext;
        logic [1:0] width;
        logic [1:0] range;
    } tcfg_t;

endpackage

// File: rtl/integ_rate_gen.sv
`timescale 1ns/1ps
module integ_rate_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic hold,
    input  logic fast,
    output logic tick
);

    logic div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= 1'b0;
        else if (clr)
            div_q <= 1'b0;
        else if (!hold)
            div_q <= ~div_q;
    end

    assign tick = !hold && (fast || div_q);

    // R3
    half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast && tick) |=> (!tick || fast));

endmodule

// File: rtl/integ_cycle_ctr.sv
`timescale 1ns/1ps
module integ_cycle_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (inc && cnt_q != TOP)
            cnt_q <= cnt_q + W'(1);
    end

    assign count = cnt_q;

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == TOP) |=> (cnt_q == TOP || cnt_q == '0));

endmodule

// File: rtl/integ_seq_fsm.sv
`timescale 1ns/1ps
module integ_seq_fsm
    import integ_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_reset,
    input  logic hold,
    input  logic ext_mode,
    input  logic cfg_chg,
    input  logic sync,
    input  logic tick,
    input  logic at_term,
    input  logic near_max,
    output logic ctr_clr,
    output logic ctr_inc,
    output logic div_clr,
    output logic pub_int,
    output logic pub_ext,
    output logic ovf_set,
    output logic ovf_clr,
    output logic array_sel,
    output logic integrating
);

    seq_state_t state_q, state_d;
    logic abort, live, ext_run;

    assign abort   = (state_q != ST_IDLE) && cfg_chg;
    assign live    = !go_reset && !hold && !abort;
    assign ext_run = (state_q == ST_XA1) || (state_q == ST_XA2);

    always_comb begin
        state_d = state_q;
        if (go_reset)
            state_d = ST_IDLE;
        else if (hold)
            state_d = state_q;
        else if (abort)
            state_d = ST_IDLE;
        else begin
            unique case (state_q)
                ST_IDLE:  state_d = ext_mode ? ST_XWAIT : ST_INT;
                ST_INT:   state_d = ST_INT;
                ST_XWAIT: state_d = sync ? ST_XA1 : ST_XWAIT;
                ST_XA1:   state_d = sync ? ST_XA2 : ST_XA1;
                ST_XA2:   state_d = sync ? ST_XA1 : ST_XA2;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        ctr_clr     = go_reset || abort;
        ctr_inc     = 1'b0;
        div_clr     = go_reset || abort;
        pub_int     = 1'b0;
        pub_ext     = 1'b0;
        ovf_set     = 1'b0;
        ovf_clr     = sync && !hold;
        array_sel   = 1'b0;
        integrating = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ctr_clr = 1'b1;
                div_clr = 1'b1;
            end
            ST_INT: begin
                integrating = !hold;
                if (live && tick) begin
                    pub_int = at_term;
                    ctr_clr = at_term;
                    ctr_inc = !at_term;
                end
            end
            ST_XWAIT: begin
                if (live && sync) begin
                    ctr_clr = 1'b1;
                    div_clr = 1'b1;
                end
            end
            ST_XA1: begin
                integrating = !hold;
                ctr_inc     = live && tick;
                ovf_set     = live && tick && near_max;
            end
            ST_XA2: begin
                integrating = !hold;
                array_sel   = 1'b1;
                if (live && sync) begin
                    pub_ext = 1'b1;
                    ctr_clr = 1'b1;
                    div_clr = 1'b1;
                end else begin
                    ctr_inc = live && tick;
                    ovf_set = live && tick && near_max;
                end
            end
            default: begin
                ctr_clr = 1'b1;
                div_clr = 1'b1;
            end
        endcase
    end

    // R6
    a2_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(array_sel) |-> $past(sync));

    // R4
    idle_on_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_reset |=> !integrating);

    // R7
    ext_only_pub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pub_ext |=> (ext_run || state_q == ST_IDLE));

endmodule

// File: rtl/integ_timer_ctrl.sv
`timescale 1ns/1ps
module integ_timer_ctrl
    import integ_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    parameter int WSTEP  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              pwr_dn,
    input  logic              ext_mode,
    input  logic [1:0]        src_sel,
    input  logic [1:0]        width_sel,
    input  logic [1:0]        range_sel,
    input  logic              sync_pulse,
    input  logic [DATA_W-1:0] conv_count,
    output logic              array_sel,
    output logic              integrating,
    output logic [DATA_W-1:0] result,
    output logic [CNT_W-1:0]  timer_val,
    output logic              timer_ovf
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;
    localparam logic [CNT_W-1:0] CNT_PRE = CNT_TOP - CNT_W'(1);

    function automatic logic [CNT_W-1:0] last_count(input logic [1:0] code);
        int unsigned sh;
        sh = CNT_W - WSTEP * int'(code);
        return CNT_W'((64'd1 << sh) - 64'd1);
    endfunction

    tcfg_t cfg_now, cfg_q;
    logic go_reset, hold, cfg_chg, tick;
    logic ctr_clr, ctr_inc, div_clr, pub_int, pub_ext, ovf_set, ovf_clr;
    logic [CNT_W-1:0] count;
    logic [DATA_W-1:0] result_q;
    logic [CNT_W-1:0] timer_q;
    logic ovf_q;

    assign cfg_now  = '{ext: ext_mode, width: width_sel, range: range_sel};
    assign go_reset = !run_en || !src_sel[1];
    assign hold     = pwr_dn || (src_sel == 2'b11);
    assign cfg_chg  = (cfg_now != cfg_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (!hold)
            cfg_q <= cfg_now;
    end

    integ_rate_gen u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (div_clr),
        .hold  (hold),
        .fast  (range_sel[1]),
        .tick  (tick)
    );

    integ_cycle_ctr #(.W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .inc   (ctr_inc),
        .count (count)
    );

    integ_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_reset    (go_reset),
        .hold        (hold),
        .ext_mode    (ext_mode),
        .cfg_chg     (cfg_chg),
        .sync        (sync_pulse),
        .tick        (tick),
        .at_term     (count == last_count(width_sel)),
        .near_max    (count == CNT_PRE),
        .ctr_clr     (ctr_clr),
        .ctr_inc     (ctr_inc),
        .div_clr     (div_clr),
        .pub_int     (pub_int),
        .pub_ext     (pub_ext),
        .ovf_set     (ovf_set),
        .ovf_clr     (ovf_clr),
        .array_sel   (array_sel),
        .integrating (integrating)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            timer_q  <= '0;
            ovf_q    <= 1'b0;
        end else begin
            if (pub_int || pub_ext)
                result_q <= conv_count;
            if (pub_ext)
                timer_q <= count;
            if (ovf_clr)
                ovf_q <= 1'b0;
            else if (ovf_set)
                ovf_q <= 1'b1;
        end
    end

    assign result    = result_q;
    assign timer_val = timer_q;
    assign timer_ovf = ovf_q;

    // R5
    freeze_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !go_reset) |=> ($stable(result_q) && $stable(timer_q)));

    // R8
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_q) |-> $past(sync_pulse));

endmodule

// File: tb/integ_timer_ctrl_test.sv
`timescale 1ns/1ps
module integ_timer_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        pwr_dn = 1'b0;
    logic        ext_mode = 1'b0;
    logic [1:0]  src_sel = 2'b10;
    logic [1:0]  width_sel = 2'b11;
    logic [1:0]  range_sel = 2'b10;
    logic        sync_pulse = 1'b0;
    logic [15:0] conv_count = 16'h0;
    logic        array_sel, integrating, timer_ovf;
    logic [15:0] result, timer_val;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] exp_res = 16'h0;

    always #2.5 clk = ~clk;

    integ_timer_ctrl uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .pwr_dn(pwr_dn),
        .ext_mode(ext_mode), .src_sel(src_sel), .width_sel(width_sel),
        .range_sel(range_sel), .sync_pulse(sync_pulse), .conv_count(conv_count),
        .array_sel(array_sel), .integrating(integrating), .result(result),
        .timer_val(timer_val), .timer_ovf(timer_ovf)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stop_run();
        run_en = 1'b0;
        step(1);
    endtask

    task automatic strobe();
        sync_pulse = 1'b1;
        step(1);
        sync_pulse = 1'b0;
    endtask

    // Internal run: period in clock edges = ticks * (range[1] ? 1 : 2)
    task automatic int_period(input string req, input logic [1:0] w,
                              input logic [1:0] r, input logic [15:0] v);
        int ticks;
        int edges;
        ticks = 1 << (16 - 4 * int'(w));
        edges = r[1] ? ticks : 2 * ticks;
        stop_run();
        ext_mode = 1'b0; src_sel = 2'b10;
        width_sel = w; range_sel = r; conv_count = v;
        run_en = 1'b1;
        step(edges);
        chk(req, "result before period end", result, exp_res);
        step(1);
        exp_res = v;
        chk(req, "result at period end", result, exp_res);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1", "integrating", integrating, 0);
        chk("R1", "array_sel", array_sel, 0);
        chk("R1", "result", result, 0);
        chk("R1", "timer_val", timer_val, 0);
        chk("R1", "timer_ovf", timer_ovf, 0);

        // R2 width 11 at full rate, periodic refresh
        int_period("R2", 2'b11, 2'b10, 16'h1234);
        chk("R2", "array_sel internal", array_sel, 0);
        chk("R2", "integrating", integrating, 1);
        conv_count = 16'h0BCD;
        step(15);
        chk("R2", "second period early", result, exp_res);
        step(1);
        exp_res = 16'h0BCD;
        chk("R2", "second period", result, exp_res);

        int_period("R2", 2'b10, 2'b11, 16'h2222);
        int_period("R2", 2'b01, 2'b10, 16'h3333);
        int_period("R2", 2'b00, 2'b11, 16'h4444);
        // R3 half-rate ranges
        int_period("R3", 2'b11, 2'b00, 16'h5151);
        int_period("R3", 2'b11, 2'b01, 16'h5252);
        int_period("R3", 2'b10, 2'b00, 16'h5353);

        // R5 power-down freeze mid period
        stop_run();
        width_sel = 2'b11; range_sel = 2'b10; conv_count = 16'h5A5A;
        run_en = 1'b1;
        step(5);
        pwr_dn = 1'b1;
        step(20);
        chk("R5", "integrating in power-down", integrating, 0);
        chk("R5", "result held in power-down", result, exp_res);
        pwr_dn = 1'b0;
        step(11);
        chk("R5", "resume before end", result, exp_res);
        step(1);
        exp_res = 16'h5A5A;
        chk("R5", "resume end", result, exp_res);

        // R5 no-operation source code freezes
        stop_run();
        conv_count = 16'h6B6B;
        run_en = 1'b1;
        step(5);
        src_sel = 2'b11;
        step(20);
        chk("R5", "integrating in src 11", integrating, 0);
        src_sel = 2'b10;
        step(11);
        chk("R5", "src 11 resume before end", result, exp_res);
        step(1);
        exp_res = 16'h6B6B;
        chk("R5", "src 11 resume end", result, exp_res);

        // R9 configuration change aborts
        stop_run();
        conv_count = 16'h0F0F;
        run_en = 1'b1;
        step(10);
        width_sel = 2'b10;
        step(257);
        chk("R9", "no publish after abort", result, exp_res);
        step(1);
        exp_res = 16'h0F0F;
        chk("R9", "restarted period", result, exp_res);

        // R4 disable keeps latched values
        run_en = 1'b0;
        step(1);
        chk("R4", "integrating off", integrating, 0);
        chk("R4", "result kept", result, exp_res);
        run_en = 1'b1;
        step(3);
        src_sel = 2'b01;
        step(1);
        chk("R4", "src 01 integrating off", integrating, 0);
        src_sel = 2'b10; conv_count = 16'h7070;
        step(256);
        chk("R4", "full period after restart early", result, exp_res);
        step(1);
        exp_res = 16'h7070;
        chk("R4", "full period after restart", result, exp_res);

        // R6 R7 external timing, full rate
        stop_run();
        ext_mode = 1'b1; range_sel = 2'b10; conv_count = 16'h7777;
        run_en = 1'b1;
        step(3);
        chk("R6", "not integrating before strobe", integrating, 0);
        strobe();
        chk("R6", "integrating first array", integrating, 1);
        chk("R6", "array_sel first", array_sel, 0);
        step(7);
        strobe();
        chk("R6", "array_sel second", array_sel, 1);
        chk("R6", "no publish at second strobe", result, exp_res);
        step(9);
        strobe();
        exp_res = 16'h7777;
        chk("R7", "result published", result, exp_res);
        chk("R7", "timer_val", timer_val, 17);
        chk("R7", "back to first array", array_sel, 0);
        conv_count = 16'h8888;
        step(4);
        strobe();
        step(2);
        strobe();
        exp_res = 16'h8888;
        chk("R7", "second measurement result", result, exp_res);
        chk("R7", "second measurement timer", timer_val, 7);

        // R3 R7 external at half rate
        stop_run();
        range_sel = 2'b00; conv_count = 16'h9999;
        run_en = 1'b1;
        step(1);
        strobe();
        step(5);
        strobe();
        step(6);
        strobe();
        exp_res = 16'h9999;
        chk("R3", "half-rate external timer", timer_val, 6);
        chk("R7", "half-rate external result", result, exp_res);

        // R6 strobes ignored while disabled
        stop_run();
        strobe();
        chk("R6", "disabled strobe integrating", integrating, 0);
        chk("R6", "disabled strobe array_sel", array_sel, 0);

        // R8 saturation and sticky flag
        range_sel = 2'b11; conv_count = 16'hAAAA;
        run_en = 1'b1;
        step(1);
        strobe();
        step(65534);
        chk("R8", "flag below top", timer_ovf, 0);
        step(1);
        chk("R8", "flag at top", timer_ovf, 1);
        step(10);
        chk("R8", "flag sticky", timer_ovf, 1);
        strobe();
        chk("R8", "flag cleared by strobe", timer_ovf, 0);
        step(2);
        strobe();
        chk("R8", "saturated timer_val", timer_val, 16'hFFFF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule